// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Sequencer

This block is a small single-address processor. Each instruction moves through a fixed set of clock states, and every state performs one register transfer. The visible registers are the program counter, the memory address register, the memory buffer register, the instruction register and a single accumulator. A four-bit condition flag set sits beside the accumulator.

Code and data share one synchronous single-port memory that lives outside the block. The memory returns read data one cycle after it samples an address. Because there is only one port, a fetch access and an operand access never overlap. The fetch sequence is the same for every instruction. After the fetch, the opcode picks a short execute sequence: load, store, add, subtract, conditional branch or halt.

The block is meant to be driven by a testbench or a system that owns the memory. Debug outputs expose the program counter, the accumulator, the flags and the current state code. This lets a reference model compare the architectural state at every instruction boundary.

Top module: `acc_cpu_seq`

## Requirements
- R1: While reset (active-low) is asserted and directly after it, the program counter, accumulator and flags are zero, the state code is 0, `halted` is low and `mem_we` is low.
- R2: Every instruction starts in state 0. The fetch then moves through state codes 0 (address register takes the PC), 1 (PC increments; `mem_addr` still shows the fetched address), 2 (buffer captures read data) and 3 (instruction register takes the buffer). It then enters the decode state, code 4.
- R3: The instruction word has the opcode in bits 15:12 and an address in bits 11:0. Opcode 0x0 loads memory at the address into the accumulator and leaves the flags unchanged.
- R4: Opcode 0x1 writes the accumulator to memory at the address. `mem_we` is high for exactly one cycle (state code 8), with `mem_wdata` equal to the accumulator. The accumulator and flags are unchanged.
- R5: Opcode 0x2 adds the memory operand to the accumulator. Opcode 0x3 computes accumulator + ~operand + 1. Both write the result back and set the flags `dbg_flags[3]`=N (result bit 15), `[2]`=Z (result zero), `[1]`=V (signed overflow) and `[0]`=C (carry out of bit 15).
- R6: Opcodes 0x8 to 0xF are branches, with the condition in bits 14:12. The conditions are: 0 always, 1 C=0, 2 C=1, 3 Z=1, 4 Z=0, 5 N=1, 6 N=0, 7 V=1. A taken branch loads the PC with the address field. A branch not taken leaves the incremented PC.
- R7: Opcode 0x7 and the unused opcodes 0x4 to 0x6 halt the block. It enters state code 9, raises `halted`, and keeps the PC, accumulator and flags frozen with no memory write until reset.
- R8: Counted from the cycle an instruction is in state 0 to the next state 0, a branch takes 5 cycles, a store 6, and a load, add or subtract 8. A halt reaches `halted` 5 cycles after its state 0.
- R9: Operand reads wait one cycle in state code 5 while the memory responds. The buffer captures the read data in state 6, and the accumulator is updated in state 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data (accumulator) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High while stopped by a halt opcode |
| dbg_pc | output | 12 | Program counter |
| dbg_acc | output | 16 | Accumulator |
| dbg_flags | output | 4 | Flags {N, Z, V, C} |
| dbg_state | output | 4 | Current state code |

## Verification
The bench targets the following corner cases:
- Arithmetic around the signed and unsigned edges: 0x7FFF+1, 0x8000+0x8000 and 1-1-1. Flag logic with the carry or overflow term wrong would show a mismatching `dbg_flags` nibble at the next instruction boundary.
- Every branch condition, each both taken and not taken. A swapped condition select would leave the program counter at the wrong instruction.
- Stores, by reading the written word back through a later load. A store that wrote the wrong word would corrupt the reloaded accumulator.
- Read wait timing. A datapath that captured read data one state early would load the previous address's word.
- Halting through both the defined and the unused opcodes, then holding for several cycles. A sequencer that left the halt state, or fell through an unused opcode, would change the program counter or assert a write.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPW = 4;

    localparam logic [OPW-1:0] OP_LOAD  = 4'h0;
    localparam logic [OPW-1:0] OP_STORE = 4'h1;
    localparam logic [OPW-1:0] OP_ADD   = 4'h2;
    localparam logic [OPW-1:0] OP_SUB   = 4'h3;
    localparam logic [OPW-1:0] OP_HALT  = 4'h7;

    typedef enum logic [3:0] {
        ST_F1    = 4'd0,
        ST_F2    = 4'd1,
        ST_F3    = 4'd2,
        ST_F4    = 4'd3,
        ST_DEC   = 4'd4,
        ST_RWAIT = 4'd5,
        ST_RCAP  = 4'd6,
        ST_EXE   = 4'd7,
        ST_STORE = 4'd8,
        ST_HALT  = 4'd9
    } seq_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    output logic [DW-1:0] res_o,
    output flags_t        flags_o
);

    logic [DW-1:0] b_eff;
    logic [DW:0]   wide;

    always_comb begin
        b_eff         = sub_i ? ~b_i : b_i;
        wide          = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, sub_i};
        res_o         = wide[DW-1:0];
        flags_o.c     = wide[DW];
        flags_o.z     = (wide[DW-1:0] == '0);
        flags_o.n     = wide[DW-1];
        flags_o.v     = (a_i[DW-1] == b_eff[DW-1]) && (wide[DW-1] != a_i[DW-1]);
    end

endmodule

// File: rtl/acc_cpu_cond.sv
module acc_cpu_cond
    import acc_cpu_pkg::*;
(
    input  logic [2:0] sel_i,
    input  flags_t     flags_i,
    output logic       take_o
);

    always_comb begin
        unique case (sel_i)
            3'd0:    take_o = 1'b1;
            3'd1:    take_o = !flags_i.c;
            3'd2:    take_o = flags_i.c;
            3'd3:    take_o = flags_i.z;
            3'd4:    take_o = !flags_i.z;
            3'd5:    take_o = flags_i.n;
            3'd6:    take_o = !flags_i.n;
            default: take_o = flags_i.v;
        endcase
    end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [OPW+AW-1:0] mem_wdata,
    input  logic [OPW+AW-1:0] mem_rdata,
    output logic              halted,
    output logic [AW-1:0]     dbg_pc,
    output logic [OPW+AW-1:0] dbg_acc,
    output logic [3:0]        dbg_flags,
    output logic [3:0]        dbg_state
);

    localparam int DW = OPW + AW;

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] pc;
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [DW-1:0] ir;
        logic [DW-1:0] acc;
        flags_t        flags;
    } regs_t;

    regs_t st_d, st_q;

    logic [OPW-1:0] op_w;
    logic [AW-1:0]  addr_w;
    logic [DW-1:0]  alu_res;
    flags_t         alu_flags;
    logic           br_take;

    assign op_w   = st_q.ir[DW-1:AW];
    assign addr_w = st_q.ir[AW-1:0];

    acc_cpu_alu #(.DW(DW)) u_alu (
        .a_i     (st_q.acc),
        .b_i     (st_q.mbr),
        .sub_i   (op_w == OP_SUB),
        .res_o   (alu_res),
        .flags_o (alu_flags)
    );

    acc_cpu_cond u_cond (
        .sel_i   (op_w[OPW-2:0]),
        .flags_i (st_q.flags),
        .take_o  (br_take)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_F1: begin
                st_d.mar   = st_q.pc;
                st_d.state = ST_F2;
            end
            ST_F2: begin
                st_d.pc    = st_q.pc + AW'(1);
                st_d.state = ST_F3;
            end
            ST_F3: begin
                st_d.mbr   = mem_rdata;
                st_d.state = ST_F4;
            end
            ST_F4: begin
                st_d.ir    = st_q.mbr;
                st_d.state = ST_DEC;
            end
            ST_DEC: begin
                if (op_w[OPW-1]) begin
                    if (br_take) st_d.pc = addr_w;
                    st_d.state = ST_F1;
                end else begin
                    unique case (op_w)
                        OP_LOAD, OP_ADD, OP_SUB: begin
                            st_d.mar   = addr_w;
                            st_d.state = ST_RWAIT;
                        end
                        OP_STORE: begin
                            st_d.mar   = addr_w;
                            st_d.state = ST_STORE;
                        end
                        default: st_d.state = ST_HALT;
                    endcase
                end
            end
            ST_RWAIT: st_d.state = ST_RCAP;
            ST_RCAP: begin
                st_d.mbr   = mem_rdata;
                st_d.state = ST_EXE;
            end
            ST_EXE: begin
                if (op_w == OP_LOAD) begin
                    st_d.acc = st_q.mbr;
                end else begin
                    st_d.acc   = alu_res;
                    st_d.flags = alu_flags;
                end
                st_d.state = ST_F1;
            end
            ST_STORE: st_d.state = ST_F1;
            ST_HALT:  st_d.state = ST_HALT;
            default:  st_d.state = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = st_q.mar;
    assign mem_we    = (st_q.state == ST_STORE);
    assign mem_wdata = st_q.acc;
    assign halted    = (st_q.state == ST_HALT);
    assign dbg_pc    = st_q.pc;
    assign dbg_acc   = st_q.acc;
    assign dbg_flags = st_q.flags;
    assign dbg_state = st_q.state;

    // R2
    mar_from_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_F1) |=> (st_q.mar == $past(st_q.pc)));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_F2) |=> (st_q.pc == $past(st_q.pc) + AW'(1)));

    // R2
    ir_from_mbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_F4) |=> (st_q.ir == $past(st_q.mbr)));

    // R9
    rcap_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_RCAP) |=> (st_q.mbr == $past(mem_rdata)));

    // R3
    load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_EXE && op_w == OP_LOAD) |=> $stable(st_q.flags));

    // R4
    store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we && st_q.state == ST_F1 && $stable(st_q.acc)));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we && $stable(st_q.pc) && $stable(st_q.acc)
                    && $stable(st_q.flags)));

endmodule

// File: tb/sim_acc_cpu_seq.sv
`timescale 1ns/1ps
module sim_acc_cpu_seq;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int CYCLE_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          halted;
    logic [AW-1:0] dbg_pc;
    logic [DW-1:0] dbg_acc;
    logic [3:0]    dbg_flags;
    logic [3:0]    dbg_state;

    always #4 clk = ~clk;

    acc_cpu_seq #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
        .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_flags(dbg_flags), .dbg_state(dbg_state)
    );

    logic [DW-1:0] ram  [0:255];
    logic [DW-1:0] mref [0:255];
    logic [DW-1:0] img  [0:255];

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[7:0]];
    end

    int checks = 0;
    int fails = 0;
    int total_cycles = 0;
    bit wd_hit = 0;

    logic [AW-1:0] m_pc;
    logic [DW-1:0] m_acc;
    logic [3:0]    m_fl;
    bit            m_halt;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    function automatic bit cond_true(input logic [2:0] s, input logic [3:0] f);
        case (s)
            3'd0: return 1'b1;
            3'd1: return f[0] == 1'b0;
            3'd2: return f[0] == 1'b1;
            3'd3: return f[2] == 1'b1;
            3'd4: return f[2] == 1'b0;
            3'd5: return f[3] == 1'b1;
            3'd6: return f[3] == 1'b0;
            default: return f[1] == 1'b1;
        endcase
    endfunction

    // Reference step of one instruction; returns the expected cycle count and a tag
    task automatic model_step(output int len, output string tag, output logic [11:0] a_out,
                              output bit was_store);
        logic [DW-1:0] w, b, r;
        logic [DW:0]   wide;
        logic [3:0]    op;
        logic [11:0]   a;
        bit            s;
        w = mref[m_pc[7:0]];
        op = w[15:12];
        a = w[11:0];
        a_out = a;
        was_store = 0;
        m_pc = m_pc + 1'b1;
        if (op[3]) begin
            if (cond_true(op[2:0], m_fl)) m_pc = a;
            len = 5; tag = "R6";
        end else if (op == 4'h0) begin
            m_acc = mref[a[7:0]];
            len = 8; tag = "R3";
        end else if (op == 4'h1) begin
            mref[a[7:0]] = m_acc;
            was_store = 1;
            len = 6; tag = "R4";
        end else if (op == 4'h2 || op == 4'h3) begin
            s = (op == 4'h3);
            b = s ? ~mref[a[7:0]] : mref[a[7:0]];
            wide = {1'b0, m_acc} + {1'b0, b} + {16'd0, s};
            r = wide[15:0];
            m_fl = {r[15], (r == 16'd0), (m_acc[15] == b[15]) && (r[15] != m_acc[15]), wide[16]};
            m_acc = r;
            len = 8; tag = "R5";
        end else begin
            m_halt = 1;
            len = 5; tag = "R7";
        end
    endtask

    task automatic load_img();
        for (int i = 0; i < 256; i++) begin
            ram[i] <= img[i];
            mref[i] = img[i];
        end
    endtask

    task automatic run_prog(input int max_instr);
        int cnt, n, len;
        string tag;
        logic [11:0] a;
        bit st;
        logic [AW-1:0] hpc;
        logic [DW-1:0] hacc;
        rst_n = 1'b0;
        load_img();
        m_pc = '0; m_acc = '0; m_fl = '0; m_halt = 0;
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk("R1", "pc in reset", dbg_pc, 0);
        chk("R1", "acc/flags in reset", {dbg_acc, dbg_flags}, 0);
        chk("R1", "state/halted/we in reset", {dbg_state, halted, mem_we}, 0);
        rst_n = 1'b1;
        cnt = 0; n = 0;
        forever begin
            @(negedge clk);
            total_cycles++;
            if (total_cycles > CYCLE_LIMIT) begin
                wd_hit = 1;
                checks++; fails++;
                $display("FAIL watchdog: actual %0d expected <= %0d cycles", total_cycles, CYCLE_LIMIT);
                return;
            end
            cnt++;
            if (dbg_state == 4'd1) chk("R2", "fetch address in state 1", mem_addr, m_pc);
            if (dbg_state == 4'd0 || halted) begin
                model_step(len, tag, a, st);
                // R8: instruction length
                chk("R8", {"cycles ", tag}, cnt, len);
                chk(tag, "pc", dbg_pc, m_pc);
                chk(tag, "acc", dbg_acc, m_acc);
                chk(tag, "flags", dbg_flags, m_fl);
                if (st) chk("R4", "stored word", ram[a[7:0]], m_acc);
                cnt = 0; n++;
                if (halted) begin
                    chk("R7", "model halt agrees", m_halt, 1);
                    hpc = dbg_pc; hacc = dbg_acc;
                    repeat (6) begin
                        @(negedge clk);
                        total_cycles++;
                        chk("R7", "stays halted, no write", {halted, mem_we, dbg_state}, {1'b1, 1'b0, 4'd9});
                    end
                    chk("R7", "pc/acc frozen", {hpc, hacc}, {dbg_pc, dbg_acc});
                    return;
                end
                if (m_halt) begin
                    chk("R7", "halt not reached", halted, 1);
                    return;
                end
                if (n >= max_instr) return;
            end
        end
    endtask

    task automatic gen_random();
        for (int i = 0; i < 128; i++) begin
            int k;
            logic [11:0] da;
            k = $urandom % 32;
            da = 12'(128 + ($urandom % 128));
            if (k < 7)       img[i] = ins(4'h0, da);
            else if (k < 11) img[i] = ins(4'h1, da);
            else if (k < 17) img[i] = ins(4'h2, da);
            else if (k < 23) img[i] = ins(4'h3, da);
            else if (k < 31) img[i] = ins(4'(8 + ($urandom % 8)), 12'($urandom % 128));
            else             img[i] = ins(4'(4 + ($urandom % 4)), 12'h000);
        end
        for (int i = 128; i < 256; i++) begin
            case ($urandom % 6)
                0: img[i] = 16'h7FFF;
                1: img[i] = 16'h8000;
                2: img[i] = 16'hFFFF;
                3: img[i] = 16'h0001;
                default: img[i] = 16'($urandom);
            endcase
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 16'h7000;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));

        // Directed: flag edges and store/reload (R3, R4, R5, R9)
        clear_img();
        img[128] = 16'h7FFF; img[129] = 16'h0001; img[130] = 16'hFFFF; img[131] = 16'h8000;
        img[0] = ins(4'h0, 12'd128);
        img[1] = ins(4'h2, 12'd129);
        img[2] = ins(4'h2, 12'd131);
        img[3] = ins(4'h0, 12'd129);
        img[4] = ins(4'h3, 12'd129);
        img[5] = ins(4'h3, 12'd129);
        img[6] = ins(4'h1, 12'd132);
        img[7] = ins(4'h0, 12'd129);
        img[8] = ins(4'h0, 12'd132);
        img[9] = ins(4'h2, 12'd130);
        img[10] = ins(4'h7, 12'd0);
        run_prog(50);

        // Directed: every branch condition taken and not taken (R6), unused opcode halts (R7)
        clear_img();
        img[128] = 16'h7FFF; img[129] = 16'h0001;
        img[0]  = ins(4'h0, 12'd129);
        img[1]  = ins(4'h3, 12'd129);
        img[2]  = ins(4'hB, 12'd4);
        img[4]  = ins(4'hC, 12'd3);
        img[5]  = ins(4'h9, 12'd3);
        img[6]  = ins(4'hA, 12'd8);
        img[8]  = ins(4'h3, 12'd129);
        img[9]  = ins(4'hD, 12'd11);
        img[11] = ins(4'hE, 12'd3);
        img[12] = ins(4'h0, 12'd128);
        img[13] = ins(4'h2, 12'd129);
        img[14] = ins(4'hF, 12'd16);
        img[16] = ins(4'h8, 12'd18);
        img[18] = ins(4'h5, 12'd0);
        run_prog(50);

        // Directed: halt on the first instruction via opcode 4 (R7, R8)
        clear_img();
        img[0] = ins(4'h4, 12'd0);
        run_prog(5);

        // Constrained random programs against the reference model
        for (int p = 0; p < 10 && !wd_hit; p++) begin
            gen_random();
            run_prog(250);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule